// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the register file that sits in front of the arbitration logic of a multi-processor interrupt distributor. It stores, for every interrupt line, an enable bit, a pending bit, an 8-bit priority (lower value wins), an 8-bit CPU target mask and a 2-bit configuration field. It also stores one global distributor enable and answers a read-only type register that reports how many CPUs and how many interrupt lines the instance was built for. All state is exported as flat vectors so that the arbiter can scan it without going through the bus.

Software reaches the bank over a simple single-cycle register port: address, byte size, write data and the ID of the CPU making the request. Read data and the error flag are combinational in the same cycle. Enable and pending bits are changed only through paired set and clear windows, so writers never need a read-modify-write. Priority and target bytes are packed four to a word. The target entries of the 32 lowest lines are banked per CPU, and the lowest 16 pending bits belong to the software-generated interrupt logic and cannot be touched here. Whenever a write really changes state the arbiter sees, the bank pulses an update strobe so that the arbiter can recompute.

Top module: `ir_dist_regs`

## Requirements
- R1: Enable bits: a size-4 write at 0x100 + 4n ORs the data into the enable bits of lines 32n..32n+31, with bit b standing for line 32n+b. A size-4 write at 0x180 + 4n clears the bits that are 1 in the data. Zero data bits leave bits unchanged. A read at either window returns the current word.
- R2: Pending bits work in the same way, with the set window at 0x200 + 4n and the clear window at 0x280 + 4n.
- R3: Pending bits 0..15 (the software-generated lines) always read as zero. Set and clear writes to them have no effect.
- R4: The priority of line n is the byte at 0x400 + n. Accesses of 1, 2 or 4 bytes are accepted at any byte offset. Byte k of the data (bits 8k+7..8k) belongs to line n+k. An access that runs past the last line is an error.
- R5: The target mask of line n is the byte at 0x800 + n. A 1-byte access covers exactly line n. A 4-byte access rounds n down to a multiple of 4 and covers four lines. A 2-byte access is an error.
- R6: A target read whose first covered line is 31 or below returns the requester's CPU ID, zero-extended. Target writes to lines 0..15 are dropped. Lines 16..31 store the written value, which shows on the target output.
- R7: The read-only type register at 0x004 reads ((NUM_CPUS-1) << 5) | (NUM_LINES/32 - 1). A write to it is an error.
- R8: Configuration words at 0xC00 + 4n hold 2 bits per line (lines 16n..16n+15). A write whose data has any bit in common with 0x55555555 raises the unsupported-mode flag for exactly the next cycle.
- R9: Bit 0 of the word at 0x000 is the global distributor enable. It is readable and writable and drives the enable output.
- R10: A request is an error if its size is not 1, 2 or 4, if it hits no mapped location, or if it is a word register access (0x000, 0x004, enable, pending or configuration) with a size other than 4. The error flag rises in the same cycle, read data is zero, and an erroneous write changes nothing.
- R11: The update strobe is high for exactly the one cycle after a write that changes an enable, pending, priority, target or global-enable bit. It stays low otherwise, including for writes that store the value already held.
- R12: After reset all state is zero and both pulse outputs are low. Read data is valid in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the bank |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_cpu | input | CPU_W | ID of the requesting CPU |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Request rejected, same cycle |
| upd_o | output | 1 | One-cycle pulse after a state-changing write |
| cfg_warn_o | output | 1 | One-cycle pulse after a configuration write selecting an unsupported mode |
| dist_en_o | output | 1 | Global distributor enable |
| line_en_o | output | NUM_LINES | Enable bit per line |
| line_pend_o | output | NUM_LINES | Pending bit per line |
| line_prio_o | output | NUM_LINES*8 | Priority byte per line |
| line_tgt_o | output | NUM_LINES*8 | Target mask byte per line |
| line_cfg_o | output | NUM_LINES*2 | Configuration pair per line |

## Verification
The bench goes after the places where byte lanes and line numbers come apart. These are priority writes at odd offsets, 4-byte target accesses at offsets that are not multiples of four, and a priority access that crosses the last line. A design that did not round the target offset down, or that swapped lane order, would leave the wrong target bytes on the output. The bench checks the banked target window with several CPU IDs, and it writes to locked lines next to writable ones. A design that leaked stored bytes into reads, or that let lines 0..15 be written, would show it there. It also sets and clears the software-generated pending bits, writes the same value twice and sends rejected requests. Here a wrong design would show nonzero low pending bits, spurious update strobes, or state changed by an erroneous write.

// File: rtl/ir_dist_pkg.sv
package ir_dist_pkg;
   // Byte offsets of each window; bases sit on boundaries large enough that
   // low address bits index words and bytes directly.
   localparam logic [11:0] OFS_CTRL  = 12'h000;
   localparam logic [11:0] OFS_TYPE  = 12'h004;
   localparam logic [11:0] OFS_ENSET = 12'h100;
   localparam logic [11:0] OFS_ENCLR = 12'h180;
   localparam logic [11:0] OFS_PNSET = 12'h200;
   localparam logic [11:0] OFS_PNCLR = 12'h280;
   localparam logic [11:0] OFS_PRIO  = 12'h400;
   localparam logic [11:0] OFS_TGT   = 12'h800;
   localparam logic [11:0] OFS_CFG   = 12'hC00;

   localparam int SGI_LINES = 16;   // lines owned by software-generated interrupts
   localparam int BANK_LINES = 32;  // target entries banked per CPU
   localparam logic [31:0] CFG_WARN_MASK = 32'h5555_5555;

   typedef enum logic [3:0] {
      RG_NONE, RG_CTRL, RG_TYPE, RG_ENSET, RG_ENCLR,
      RG_PNSET, RG_PNCLR, RG_PRIO, RG_TGT, RG_CFG
   } region_e;
endpackage

// File: rtl/ir_bitarray.sv
// Bank of 32-bit words with set/clear write ports; word 0 can carry a
// mask of bits that are never allowed to become 1.
module ir_bitarray #(
   parameter int          WORDS   = 2,
   parameter int          IDX_W   = 1,
   parameter logic [31:0] W0_MASK = 32'hFFFF_FFFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_we,
   input  logic                  clr_we,
   input  logic [IDX_W-1:0]      widx,
   input  logic [31:0]           wdata,
   output logic [WORDS*32-1:0]   bits_o,
   output logic [31:0]           rword_o,
   output logic                  chg_o
);
   logic [WORDS-1:0] chg_w;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [31:0] KEEP = (w == 0) ? W0_MASK : 32'hFFFF_FFFF;
      logic [31:0] q;
      logic [31:0] nxt;
      logic        sel;
      assign sel = (widx == IDX_W'(w));
      always_comb begin
         nxt = q;
         if (sel && set_we)      nxt = q | wdata;
         else if (sel && clr_we) nxt = q & ~wdata;
         nxt = nxt & KEEP;
      end
      assign chg_w[w] = (nxt != q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= nxt;
      end
      assign bits_o[w*32 +: 32] = q;
   end

   always_comb begin
      rword_o = '0;
      for (int w = 0; w < WORDS; w++)
         if (widx == IDX_W'(w)) rword_o = bits_o[w*32 +: 32];
   end
   assign chg_o = |chg_w;

   // checker state: remember the last clear request
   logic             clr_d;
   logic [IDX_W-1:0] idx_d;
   logic [31:0]      data_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_d <= 1'b0; idx_d <= '0; data_d <= '0;
      end else begin
         clr_d <= clr_we && !set_we; idx_d <= widx; data_d <= wdata;
      end
   end

   // R1 / R2: bits named in a clear request are zero afterwards
   assert_clear_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clr_d |-> ((bits_o[{idx_d, 5'b00000} +: 32] & data_d) == 32'h0));
   // R3: masked bits of word 0 never become set
   assert_masked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((bits_o[31:0] & ~W0_MASK) == 32'h0));
endmodule

// File: rtl/ir_bytefield.sv
// Array of one byte per line, written 1..4 bytes at a time from a base
// line; the lowest LOCKED lines ignore writes.
module ir_bytefield #(
   parameter int LINES  = 64,
   parameter int OFF_W  = 6,
   parameter int LOCKED = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [OFF_W-1:0]    base,
   input  logic [2:0]          size,
   input  logic [31:0]         wdata,
   output logic [LINES*8-1:0]  bytes_o,
   output logic [31:0]         rdata_o,
   output logic                chg_o
);
   logic [LINES-1:0] chg_l;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [7:0] q;
      logic [7:0] nxt;
      if (i < LOCKED) begin : g_locked
         assign nxt = q;
      end else begin : g_open
         logic [OFF_W:0] d;
         logic           hit;
         assign d   = (OFF_W+1)'(i) - {1'b0, base};
         assign hit = we && (d < (OFF_W+1)'(size));
         assign nxt = hit ? wdata[{d[1:0], 3'b000} +: 8] : q;
      end
      assign chg_l[i] = (nxt != q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= nxt;
      end
      assign bytes_o[i*8 +: 8] = q;
   end

   for (genvar k = 0; k < 4; k++) begin : g_rd
      logic [OFF_W:0] ridx;
      assign ridx = {1'b0, base} + (OFF_W+1)'(k);
      assign rdata_o[8*k +: 8] = ((3'(k) < size) && (ridx < (OFF_W+1)'(LINES)))
                                 ? bytes_o[{ridx[OFF_W-1:0], 3'b000} +: 8] : 8'h00;
   end
   assign chg_o = |chg_l;

   if (LOCKED > 0) begin : g_lock_chk
      // R6: locked entries never move
      assert_locked_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
         we |=> (bytes_o[LOCKED*8-1:0] == $past(bytes_o[LOCKED*8-1:0])));
   end
endmodule

// File: rtl/ir_dist_regs.sv
module ir_dist_regs
   import ir_dist_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 4,
   localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [11:0]            req_addr,
   input  logic [2:0]             req_size,
   input  logic [CPU_W-1:0]       req_cpu,
   input  logic [31:0]            req_wdata,
   output logic [31:0]            rsp_rdata,
   output logic                   rsp_err,
   output logic                   upd_o,
   output logic                   cfg_warn_o,
   output logic                   dist_en_o,
   output logic [NUM_LINES-1:0]   line_en_o,
   output logic [NUM_LINES-1:0]   line_pend_o,
   output logic [NUM_LINES*8-1:0] line_prio_o,
   output logic [NUM_LINES*8-1:0] line_tgt_o,
   output logic [NUM_LINES*2-1:0] line_cfg_o
);
   localparam int WORDS     = NUM_LINES / 32;
   localparam int CFG_WORDS = NUM_LINES / 16;
   localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int CIDX_W    = $clog2(CFG_WORDS);
   localparam int OFF_W     = $clog2(NUM_LINES);
   localparam logic [31:0] TYPE_VAL = 32'(((NUM_CPUS - 1) << 5) | (WORDS - 1));
   localparam logic [31:0] PEND_W0_MASK = 32'hFFFF_FFFF << SGI_LINES;

   if ((NUM_LINES % 32) != 0 || NUM_LINES < 32 || NUM_LINES > 1024) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of 32 between 32 and 1024");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > 8) begin : g_bad_cpus
      $error("NUM_CPUS must be between 1 and 8");
   end

   // ---------------- decode ----------------
   function automatic logic in_rng(input logic [11:0] a, input logic [11:0] b, input int len);
      return (a >= b) && (a < b + 12'(len));
   endfunction

   region_e rgn;
   always_comb begin
      if      (req_addr == OFS_CTRL)                    rgn = RG_CTRL;
      else if (req_addr == OFS_TYPE)                    rgn = RG_TYPE;
      else if (in_rng(req_addr, OFS_ENSET, WORDS*4))    rgn = RG_ENSET;
      else if (in_rng(req_addr, OFS_ENCLR, WORDS*4))    rgn = RG_ENCLR;
      else if (in_rng(req_addr, OFS_PNSET, WORDS*4))    rgn = RG_PNSET;
      else if (in_rng(req_addr, OFS_PNCLR, WORDS*4))    rgn = RG_PNCLR;
      else if (in_rng(req_addr, OFS_PRIO, NUM_LINES))   rgn = RG_PRIO;
      else if (in_rng(req_addr, OFS_TGT, NUM_LINES))    rgn = RG_TGT;
      else if (in_rng(req_addr, OFS_CFG, CFG_WORDS*4))  rgn = RG_CFG;
      else                                              rgn = RG_NONE;
   end

   logic sz_ok, word_ok, prio_fit, tgt_banked;
   logic [OFF_W-1:0] tgt_base;
   assign sz_ok    = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
   assign word_ok  = (req_size == 3'd4) && (req_addr[1:0] == 2'b00);
   assign prio_fit = ({1'b0, req_addr[OFF_W-1:0]} + (OFF_W+1)'(req_size))
                     <= (OFF_W+1)'(NUM_LINES);
   assign tgt_base = (req_size == 3'd4) ? {req_addr[OFF_W-1:2], 2'b00} : req_addr[OFF_W-1:0];
   assign tgt_banked = ({1'b0, tgt_base} < (OFF_W+1)'(BANK_LINES));

   // ---------------- storage ----------------
   logic        gl_en, wr_ok, bad;
   logic [31:0] en_word, pn_word, cfg_word, pr_rd, tg_rd, rd;
   logic        en_chg, pn_chg, pr_chg, tg_chg, gl_chg;

   ir_bitarray #(.WORDS(WORDS), .IDX_W(IDX_W), .W0_MASK(32'hFFFF_FFFF)) u_en (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_ok && rgn == RG_ENSET), .clr_we(wr_ok && rgn == RG_ENCLR),
      .widx(req_addr[IDX_W+1:2]), .wdata(req_wdata),
      .bits_o(line_en_o), .rword_o(en_word), .chg_o(en_chg));

   ir_bitarray #(.WORDS(WORDS), .IDX_W(IDX_W), .W0_MASK(PEND_W0_MASK)) u_pn (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_ok && rgn == RG_PNSET), .clr_we(wr_ok && rgn == RG_PNCLR),
      .widx(req_addr[IDX_W+1:2]), .wdata(req_wdata),
      .bits_o(line_pend_o), .rword_o(pn_word), .chg_o(pn_chg));

   ir_bytefield #(.LINES(NUM_LINES), .OFF_W(OFF_W), .LOCKED(0)) u_pr (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && rgn == RG_PRIO),
      .base(req_addr[OFF_W-1:0]), .size(req_size), .wdata(req_wdata),
      .bytes_o(line_prio_o), .rdata_o(pr_rd), .chg_o(pr_chg));

   ir_bytefield #(.LINES(NUM_LINES), .OFF_W(OFF_W), .LOCKED(SGI_LINES)) u_tg (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && rgn == RG_TGT),
      .base(tgt_base), .size(req_size), .wdata(req_wdata),
      .bytes_o(line_tgt_o), .rdata_o(tg_rd), .chg_o(tg_chg));

   for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (wr_ok && rgn == RG_CFG && req_addr[CIDX_W+1:2] == CIDX_W'(w))
            q <= req_wdata;
      end
      assign line_cfg_o[w*32 +: 32] = q;
   end
   always_comb begin
      cfg_word = '0;
      for (int w = 0; w < CFG_WORDS; w++)
         if (req_addr[CIDX_W+1:2] == CIDX_W'(w)) cfg_word = line_cfg_o[w*32 +: 32];
   end

   // ---------------- response ----------------
   always_comb begin
      rd  = '0;
      bad = 1'b0;
      case (rgn)
         RG_CTRL:            if (!word_ok) bad = 1'b1; else rd = {31'b0, gl_en};
         RG_TYPE:            if (!word_ok || req_write) bad = 1'b1; else rd = TYPE_VAL;
         RG_ENSET, RG_ENCLR: if (!word_ok) bad = 1'b1; else rd = en_word;
         RG_PNSET, RG_PNCLR: if (!word_ok) bad = 1'b1; else rd = pn_word;
         RG_PRIO:            if (!prio_fit) bad = 1'b1; else rd = pr_rd;
         RG_TGT: begin
            if (req_size == 3'd2) bad = 1'b1;
            else if (tgt_banked)  rd = 32'(req_cpu);
            else                  rd = tg_rd;
         end
         RG_CFG:             if (!word_ok) bad = 1'b1; else rd = cfg_word;
         default:            bad = 1'b1;
      endcase
      if (!sz_ok) bad = 1'b1;
   end

   assign rsp_err   = req_valid && bad;
   assign rsp_rdata = (req_valid && !req_write && !bad) ? rd : 32'h0;
   assign wr_ok     = req_valid && req_write && !bad;
   assign gl_chg    = wr_ok && (rgn == RG_CTRL) && (req_wdata[0] != gl_en);

   logic upd_q, warn_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gl_en  <= 1'b0;
         upd_q  <= 1'b0;
         warn_q <= 1'b0;
      end else begin
         if (wr_ok && rgn == RG_CTRL) gl_en <= req_wdata[0];
         upd_q  <= wr_ok && (en_chg || pn_chg || pr_chg || tg_chg || gl_chg);
         warn_q <= wr_ok && (rgn == RG_CFG) && ((req_wdata & CFG_WARN_MASK) != 32'h0);
      end
   end
   assign upd_o      = upd_q;
   assign cfg_warn_o = warn_q;
   assign dist_en_o  = gl_en;

   // ---------------- assertions ----------------
   assert_err_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && rsp_err) |=>
      ($stable(line_en_o) && $stable(line_pend_o) && $stable(line_prio_o) &&
       $stable(line_tgt_o) && $stable(line_cfg_o) && $stable(dist_en_o)));
   assert_sgi_pend_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      line_pend_o[SGI_LINES-1:0] == '0);
   assert_type_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == OFS_TYPE && req_size == 3'd4)
      |-> (rsp_rdata == TYPE_VAL));
   assert_banked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 3'd1 &&
       req_addr >= OFS_TGT && req_addr < OFS_TGT + 12'(BANK_LINES))
      |-> (rsp_rdata == 32'(req_cpu)));
   assert_upd_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> $past(req_valid && req_write && !rsp_err));
   assert_warn_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_warn_o |-> $past(req_valid && req_write && req_addr >= OFS_CFG));
endmodule

// File: tb/ir_dist_regs_tb.sv
module ir_dist_regs_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 64;
   localparam int NC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [1:0]  req_cpu = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic rsp_err, upd_o, cfg_warn_o, dist_en_o;
   logic [NL-1:0] line_en_o, line_pend_o;
   logic [NL*8-1:0] line_prio_o, line_tgt_o;
   logic [NL*2-1:0] line_cfg_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   ir_dist_regs #(.NUM_LINES(NL), .NUM_CPUS(NC)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_cpu(req_cpu), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .upd_o(upd_o), .cfg_warn_o(cfg_warn_o),
      .dist_en_o(dist_en_o), .line_en_o(line_en_o), .line_pend_o(line_pend_o),
      .line_prio_o(line_prio_o), .line_tgt_o(line_tgt_o), .line_cfg_o(line_cfg_o));

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // ---------------- reference model ----------------
   logic [31:0] en_m[2], pn_m[2], cfg_m[4];
   logic [7:0]  pr_m[NL], tg_m[NL];
   bit          gl_m;

   task automatic chk(input string tag, input string what, input logic [511:0] act,
                      input logic [511:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input bit w, input int a, input int sz, input int cpu,
                                 input logic [31:0] wd, output logic [31:0] rd,
                                 output bit er, output bit up, output bit wn);
      int off, b;
      logic [31:0] nv;
      rd = 0; er = 0; up = 0; wn = 0;
      if (!(sz == 1 || sz == 2 || sz == 4)) er = 1;
      else if (a == 0) begin
         if (sz != 4) er = 1;
         else begin rd = {31'b0, gl_m}; if (w) begin up = (gl_m != wd[0]); gl_m = wd[0]; end end
      end else if (a == 4) begin
         if (sz != 4 || w) er = 1; else rd = ((NC - 1) << 5) | (NL / 32 - 1);
      end else if ((a >= 'h100 && a < 'h108) || (a >= 'h180 && a < 'h188)) begin
         if (sz != 4 || a % 4 != 0) er = 1;
         else begin
            off = (a % 'h80) / 4; rd = en_m[off];
            if (w) begin
               nv = (a < 'h180) ? (en_m[off] | wd) : (en_m[off] & ~wd);
               up = (nv != en_m[off]); en_m[off] = nv;
            end
         end
      end else if ((a >= 'h200 && a < 'h208) || (a >= 'h280 && a < 'h288)) begin
         if (sz != 4 || a % 4 != 0) er = 1;
         else begin
            off = (a % 'h80) / 4; rd = pn_m[off];
            if (w) begin
               nv = (a < 'h280) ? (pn_m[off] | wd) : (pn_m[off] & ~wd);
               if (off == 0) nv[15:0] = 16'h0;
               up = (nv != pn_m[off]); pn_m[off] = nv;
            end
         end
      end else if (a >= 'h400 && a < 'h400 + NL) begin
         off = a - 'h400;
         if (off + sz > NL) er = 1;
         else for (int k = 0; k < sz; k++) begin
            rd[8*k +: 8] = pr_m[off + k];
            if (w) begin
               if (pr_m[off + k] != wd[8*k +: 8]) up = 1;
               pr_m[off + k] = wd[8*k +: 8];
            end
         end
      end else if (a >= 'h800 && a < 'h800 + NL) begin
         off = a - 'h800;
         b = (sz == 4) ? (off / 4) * 4 : off;
         if (sz == 2) er = 1;
         else for (int k = 0; k < sz; k++) begin
            if (b >= 32) rd[8*k +: 8] = tg_m[b + k];
            if (w && b + k >= 16) begin
               if (tg_m[b + k] != wd[8*k +: 8]) up = 1;
               tg_m[b + k] = wd[8*k +: 8];
            end
         end
         if (!er && b < 32) rd = cpu;
      end else if (a >= 'hC00 && a < 'hC10) begin
         if (sz != 4 || a % 4 != 0) er = 1;
         else begin
            off = (a - 'hC00) / 4; rd = cfg_m[off];
            if (w) begin cfg_m[off] = wd; wn = ((wd & 32'h5555_5555) != 0); end
         end
      end else er = 1;
      if (er) begin rd = 0; up = 0; wn = 0; end
   endfunction

   task automatic cmp_state(input string tag);
      logic [511:0] ep, et;
      logic [127:0] ec;
      for (int i = 0; i < NL; i++) begin ep[8*i +: 8] = pr_m[i]; et[8*i +: 8] = tg_m[i]; end
      for (int i = 0; i < 4; i++) ec[32*i +: 32] = cfg_m[i];
      chk(tag, "enable vector", 512'(line_en_o), 512'({en_m[1], en_m[0]}));
      chk(tag, "pending vector", 512'(line_pend_o), 512'({pn_m[1], pn_m[0]}));
      chk(tag, "priority vector", line_prio_o, ep);
      chk(tag, "target vector", line_tgt_o, et);
      chk(tag, "config vector", 512'(line_cfg_o), 512'(ec));
      chk(tag, "global enable", 512'(dist_en_o), 512'(gl_m));
   endtask

   // one request, then compare response, pulses and all exported state
   task automatic access(input bit w, input int a, input int sz, input int cpu,
                         input logic [31:0] wd, input string tag);
      logic [31:0] erd;
      bit eer, eup, ewn;
      @(negedge clk);
      req_valid = 1; req_write = w; req_addr = 12'(a); req_size = 3'(sz);
      req_cpu = 2'(cpu); req_wdata = wd;
      model(w, a, sz, cpu, wd, erd, eer, eup, ewn);
      #1;
      chk(tag, "error flag", 512'(rsp_err), 512'(eer));
      if (!w) chk(tag, "read data", 512'(rsp_rdata), 512'(erd));
      @(negedge clk);
      req_valid = 0; req_write = 0;
      #1;
      chk({tag, "/R11"}, "update strobe", 512'(upd_o), 512'(eup));
      chk({tag, "/R8"}, "mode flag", 512'(cfg_warn_o), 512'(ewn));
      cmp_state(tag);
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin en_m[i] = 0; pn_m[i] = 0; end
      for (int i = 0; i < 4; i++) cfg_m[i] = 0;
      for (int i = 0; i < NL; i++) begin pr_m[i] = 0; tg_m[i] = 0; end
      gl_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R12: reset state
      chk("R12", "update after reset", 512'(upd_o), 512'(0));
      chk("R12", "mode flag after reset", 512'(cfg_warn_o), 512'(0));
      chk("R12", "error idle", 512'(rsp_err), 512'(0));
      cmp_state("R12");

      access(0, 'h004, 4, 0, 0, "R7");                 // type register
      access(1, 'h004, 4, 0, 32'h1, "R7");             // read-only
      access(0, 'h100, 4, 0, 0, "R12");                // reset value of enable
      access(1, 'h000, 4, 0, 32'h1, "R9");
      access(0, 'h000, 4, 0, 0, "R9");
      access(1, 'h000, 4, 0, 32'h1, "R9");             // same value: no strobe
      // R1 enable set/clear
      access(1, 'h100, 4, 0, 32'hA5A5_0003, "R1");
      access(1, 'h104, 4, 0, 32'h8000_0001, "R1");
      access(1, 'h100, 4, 0, 32'h0, "R1");
      access(1, 'h180, 4, 0, 32'h0000_0001, "R1");
      access(1, 'h184, 4, 0, 32'h0, "R1");
      access(0, 'h180, 4, 0, 0, "R1");
      access(0, 'h104, 4, 0, 0, "R1");
      // R2/R3 pending
      access(1, 'h200, 4, 0, 32'hFFFF_FFFF, "R3");
      access(0, 'h200, 4, 0, 0, "R3");
      access(1, 'h280, 4, 0, 32'h0001_0000, "R2");
      access(1, 'h280, 4, 0, 32'h0000_FFFF, "R3");
      access(1, 'h204, 4, 0, 32'h0000_0010, "R2");
      access(0, 'h284, 4, 0, 0, "R2");
      // R4 priority
      access(1, 'h405, 1, 0, 32'h0000_0040, "R4");
      access(1, 'h40A, 2, 0, 32'h0000_1234, "R4");
      access(1, 'h43C, 4, 0, 32'hDEAD_BEEF, "R4");
      access(1, 'h43D, 4, 0, 32'h1111_1111, "R4");     // crosses end
      access(1, 'h43F, 2, 0, 32'h2222, "R4");          // crosses end
      access(0, 'h404, 4, 0, 0, "R4");
      access(0, 'h409, 2, 0, 0, "R4");
      access(0, 'h43F, 1, 0, 0, "R4");
      access(1, 'h405, 1, 0, 32'h0000_0040, "R11");    // same value
      // R5/R6 targets
      access(1, 'h80C, 4, 0, 32'h0F0F_0F0F, "R6");     // lines 12..15 locked
      access(1, 'h812, 4, 1, 32'h0807_0605, "R6");     // aligns to 16..19
      access(0, 'h810, 4, 2, 0, "R6");
      access(0, 'h81F, 1, 3, 0, "R6");
      access(1, 'h80E, 1, 0, 32'h3, "R6");             // single locked line
      access(1, 'h828, 1, 0, 32'h0000_0003, "R5");
      access(1, 'h82B, 4, 0, 32'h4433_2211, "R5");     // aligns to 40..43
      access(0, 'h829, 1, 1, 0, "R5");
      access(0, 'h82A, 4, 1, 0, "R5");
      access(1, 'h83D, 1, 0, 32'h0000_0009, "R5");
      access(0, 'h83C, 4, 0, 0, "R5");
      access(1, 'h830, 2, 0, 32'hFFFF, "R5");          // size 2 rejected
      // R8 configuration
      access(1, 'hC04, 4, 0, 32'hAAAA_AAAA, "R8");
      access(1, 'hC08, 4, 0, 32'h0000_0001, "R8");
      access(0, 'hC04, 4, 0, 0, "R8");
      // R10 errors
      access(1, 'h100, 3, 0, 32'hFFFF_FFFF, "R10");
      access(0, 'h300, 4, 0, 0, "R10");
      access(1, 'h000, 1, 0, 32'h0, "R10");
      access(1, 'h102, 4, 0, 32'hFFFF_FFFF, "R10");
      access(1, 'h108, 4, 0, 32'hFFFF_FFFF, "R10");
      access(1, 'h204, 2, 0, 32'hFFFF_FFFF, "R10");
      access(0, 'hC10, 4, 0, 0, "R10");
      access(1, 'h440, 1, 0, 32'h7, "R10");
      // idle cycles: nothing pulses
      repeat (3) begin
         @(negedge clk); #1;
         chk("R11", "idle update strobe", 512'(upd_o), 512'(0));
         cmp_state("R11");
      end
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R12 watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule